// File: doc/BRIEF.md
# Three-Channel LED Dimmer with Blink Masks

This block drives the cathodes of a red, green and blue LED. Each colour takes one byte from a 24-bit settings bus: the lower four bits pick a brightness level from a sixteen-step table that grows roughly logarithmically, and the upper four bits pick one of sixteen 16-bit blink masks. A pulse on the `load` input captures all three bytes at once. Until the next pulse, the settings bus may change freely with no effect on the outputs.

Each colour has its own PWM counter. The three counters share one period but start a third of a period apart, so their pulses do not all begin on the same clock. A prescaler divides the system clock into a blink tick. On every tick, each mask rotates left by one bit, and the bit shifted out of the top gates that colour's PWM for the next tick interval. The outputs are registered and active low.

Top module: `rgb_blink_dimmer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, all of `led_n` is 1. After reset, all brightness levels are zero and every blink mask is 0xFFFF, which keeps every channel permanently enabled.
- R2: Channel c takes its brightness index from `setting[8c+3:8c]`, where c is 0 for red, 1 for green and 2 for blue. Indices 0 to 15 give the 10-bit duties 0, 1, 2, 4, 6, 10, 16, 25, 40, 64, 101, 161, 256, 406, 644 and 1023. With its gate enabled, a channel is low for exactly that many cycles in every 2^PWM_W-cycle period; for PWM_W below 10, the duty is the top PWM_W bits of the table value.
- R3: Channel c takes its mask index from `setting[8c+7:8c+4]`. Indices 0 to 15 give the masks 0xFFFF, 0x00FF, 0x0F0F, 0x3333, 0x5555, 0x000F, 0x0003, 0x0001, 0x0000, 0xFF00, 0xF0F0, 0xCCCC, 0xAAAA, 0xFFF0, 0xFFFC and 0xFFFE.
- R4: A load sets each gate to bit 15 of its new mask and stores the mask rotated left by one. Each later tick sets the gate to the stored bit 15 and rotates the mask again. After a load, the gate therefore follows mask bits 15, 14, ..., 0 and then repeats, with each bit holding for one tick interval.
- R5: Settings are captured only in a cycle where `load` is 1. A change on `setting` without a load leaves the brightness and blink behaviour unchanged.
- R6: In each cycle, `led_n[c]` is 0 exactly when, one clock earlier, channel c's PWM was high and its gate was set.
- R7: The PWM counter of channel c starts after reset at floor(c*2^PWM_W/3). As a result, green begins its period 2^PWM_W - floor(2^PWM_W/3) cycles after red, and blue begins floor(2^PWM_W/3) + 1 cycles after red.
- R8: A newly loaded duty takes effect only when the channel's counter wraps to zero, so a period in progress completes with the old duty.
- R9: The blink tick occurs once every TICK_DIV clocks. A load restarts the tick count, so the first tick after a load comes TICK_DIV cycles later, and all three masks advance together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for the settings bus |
| setting | input | 24 | Byte per colour: mask index in the upper nibble, brightness index in the lower nibble |
| led_n | output | 3 | Active-low LED drives: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench builds the block with a 10-bit PWM and TICK_DIV set to 1024, so one blink interval is exactly one PWM period. With full brightness, a gate-on interval then holds exactly 1023 low cycles and a gate-off interval holds none, which lets the bench read all sixteen mask bits for all three colours directly from low-cycle counts. The full 10-bit duty table and the one-third phase offsets (683 and 342 cycles) are checked at their real resolution. Because a whole mask sweep takes only 16K cycles, every mask in the table can be run.

// File: rtl/rgbd_pkg.sv
package rgbd_pkg;
  localparam int NCH   = 3;
  localparam int LVL_W = 10;
  localparam int MSK_W = 16;
  localparam int SET_W = 8;

  function automatic logic [LVL_W-1:0] level_duty(input logic [3:0] idx);
    logic [LVL_W-1:0] d;
    case (idx)
      4'd0:  d = 10'd0;
      4'd1:  d = 10'd1;
      4'd2:  d = 10'd2;
      4'd3:  d = 10'd4;
      4'd4:  d = 10'd6;
      4'd5:  d = 10'd10;
      4'd6:  d = 10'd16;
      4'd7:  d = 10'd25;
      4'd8:  d = 10'd40;
      4'd9:  d = 10'd64;
      4'd10: d = 10'd101;
      4'd11: d = 10'd161;
      4'd12: d = 10'd256;
      4'd13: d = 10'd406;
      4'd14: d = 10'd644;
      default: d = 10'd1023;
    endcase
    return d;
  endfunction

  function automatic logic [MSK_W-1:0] blink_mask(input logic [3:0] idx);
    logic [MSK_W-1:0] m;
    case (idx)
      4'd0:  m = 16'hFFFF;
      4'd1:  m = 16'h00FF;
      4'd2:  m = 16'h0F0F;
      4'd3:  m = 16'h3333;
      4'd4:  m = 16'h5555;
      4'd5:  m = 16'h000F;
      4'd6:  m = 16'h0003;
      4'd7:  m = 16'h0001;
      4'd8:  m = 16'h0000;
      4'd9:  m = 16'hFF00;
      4'd10: m = 16'hF0F0;
      4'd11: m = 16'hCCCC;
      4'd12: m = 16'hAAAA;
      4'd13: m = 16'hFFF0;
      4'd14: m = 16'hFFFC;
      default: m = 16'hFFFE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rgbd_prescaler.sv
module rgbd_prescaler #(
  parameter int DIV = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/rgbd_pwm_lane.sv
module rgbd_pwm_lane #(
  parameter int W     = 10,
  parameter int PHASE = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] duty_next,
  output logic         pwm_hi,
  output logic         wrap,
  output logic [W-1:0] duty_act
);
  logic [W-1:0] cnt;

  assign wrap   = (cnt == {W{1'b1}});
  assign pwm_hi = (cnt < duty_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= W'(PHASE);
      duty_act <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) duty_act <= duty_next;
    end
  end
endmodule

// File: rtl/rgbd_blink_lane.sv
module rgbd_blink_lane #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          tick,
  input  logic [MW-1:0] mask_in,
  output logic          gate
);
  logic [MW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      gate   <= 1'b1;
    end else if (load) begin
      gate   <= mask_in[MW-1];
      mask_q <= {mask_in[MW-2:0], mask_in[MW-1]};
    end else if (tick) begin
      gate   <= mask_q[MW-1];
      mask_q <= {mask_q[MW-2:0], mask_q[MW-1]};
    end
  end
endmodule

// File: rtl/rgb_blink_dimmer.sv
module rgb_blink_dimmer #(
  parameter int PWM_W    = 10,
  parameter int TICK_DIV = 65536
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [23:0] setting,
  output logic [2:0]  led_n
);
  import rgbd_pkg::*;

  localparam int PER = 1 << PWM_W;

  logic                   tick;
  logic [NCH-1:0]         gate_vec;
  logic [NCH-1:0]         pwm_vec;
  logic [NCH-1:0]         wrap_vec;
  logic [NCH*PWM_W-1:0]   duty_flat;

  rgbd_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .restart(load), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int PH = (c * PER) / NCH;
    logic [3:0]       lvl_idx;
    logic [3:0]       msk_idx;
    logic [LVL_W-1:0] lvl_full;
    logic [PWM_W-1:0] duty_pend;

    assign lvl_idx  = setting[c*SET_W +: 4];
    assign msk_idx  = setting[c*SET_W + 4 +: 4];
    assign lvl_full = level_duty(lvl_idx);

    always_ff @(posedge clk) begin
      if (rst) duty_pend <= '0;
      else if (load) duty_pend <= lvl_full[LVL_W-1 -: PWM_W];
    end

    rgbd_pwm_lane #(.W(PWM_W), .PHASE(PH)) u_pwm (
      .clk(clk), .rst(rst), .duty_next(duty_pend),
      .pwm_hi(pwm_vec[c]), .wrap(wrap_vec[c]),
      .duty_act(duty_flat[c*PWM_W +: PWM_W])
    );

    rgbd_blink_lane #(.MW(MSK_W)) u_blink (
      .clk(clk), .rst(rst), .load(load), .tick(tick),
      .mask_in(blink_mask(msk_idx)), .gate(gate_vec[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) led_n <= '1;
    else led_n <= ~(pwm_vec & gate_vec);
  end
endmodule

// File: rtl/rgbd_checker.sv
module rgbd_checker #(
  parameter int PWM_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               load,
  input logic               tick,
  input logic [2:0]         led_n,
  input logic [2:0]         gate,
  input logic [2:0]         pwm_hi,
  input logic [2:0]         wrap,
  input logic [3*PWM_W-1:0] duty_flat
);
  assert_reset_dark_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> led_n == 3'b111);

  assert_active_low_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> led_n == ~($past(pwm_hi) & $past(gate)));

  assert_gate_moves_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(gate) |-> $past(tick || load));

  assert_tick_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  for (genvar c = 0; c < 3; c++) begin : g_duty
    assert_duty_on_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(duty_flat[c*PWM_W +: PWM_W]) |-> $past(wrap[c]));
  end
endmodule

bind rgb_blink_dimmer rgbd_checker #(.PWM_W(PWM_W)) chk_i (
  .clk(clk), .rst(rst), .load(load), .tick(tick), .led_n(led_n),
  .gate(gate_vec), .pwm_hi(pwm_vec), .wrap(wrap_vec), .duty_flat(duty_flat)
);

// File: tb/rgb_blink_dimmer_tb_top.sv
module rgb_blink_dimmer_tb_top;
  localparam int PWM_W    = 10;
  localparam int TICK_DIV = 1024;
  localparam int PER      = 1 << PWM_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [23:0] setting = '0;
  logic [2:0]  led_n;

  typedef struct {
    int    e0;
    int    e1;
    int    e2;
    int    len;
    string tag;
  } win_t;

  win_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  rgb_blink_dimmer #(.PWM_W(PWM_W), .TICK_DIV(TICK_DIV)) dut_i (
    .clk(clk), .rst(rst), .load(load), .setting(setting), .led_n(led_n)
  );

  function automatic int ref_duty(input int idx);
    int t[16] = '{0, 1, 2, 4, 6, 10, 16, 25, 40, 64, 101, 161, 256, 406, 644, 1023};
    return t[idx];
  endfunction

  function automatic logic [15:0] ref_mask(input int idx);
    logic [15:0] t[16] = '{16'hFFFF, 16'h00FF, 16'h0F0F, 16'h3333, 16'h5555, 16'h000F,
                           16'h0003, 16'h0001, 16'h0000, 16'hFF00, 16'hF0F0, 16'hCCCC,
                           16'hAAAA, 16'hFFF0, 16'hFFFC, 16'hFFFE};
    return t[idx];
  endfunction

  task automatic check_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [23:0] v);
    @(negedge clk);
    setting = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic push_win(input int a, input int b, input int c, input int len, input string tag);
    win_t w;
    w.e0 = a; w.e1 = b; w.e2 = c; w.len = len; w.tag = tag;
    q.push_back(w);
  endtask

  task automatic brightness(input int r, input int g, input int b, input string tag);
    apply({4'h0, 4'(b), 4'h0, 4'(g), 4'h0, 4'(r)});
    repeat (PER + 80) @(negedge clk);
    push_win(ref_duty(r), ref_duty(g), ref_duty(b), PER, tag);
    wait (q.size() == 0);
  endtask

  task automatic mask_run(input int mr, input int mg, input int mb);
    logic [15:0] pr, pg, pb;
    pr = ref_mask(mr); pg = ref_mask(mg); pb = ref_mask(mb);
    apply({4'(mb), 4'hF, 4'(mg), 4'hF, 4'(mr), 4'hF});
    for (int k = 0; k < 16; k++)
      push_win(pr[15-k] ? PER-1 : 0, pg[15-k] ? PER-1 : 0, pb[15-k] ? PER-1 : 0,
               TICK_DIV, $sformatf("R3/R4/R9 masks %0d,%0d,%0d step %0d", mr, mg, mb, k));
    wait (q.size() == 0);
  endtask

  // Monitor: pops one expected window per item and counts low cycles per colour
  initial begin
    forever begin
      win_t w;
      int lc[3];
      wait (q.size() > 0);
      w = q[0];
      lc = '{0, 0, 0};
      for (int i = 0; i < w.len; i++) begin
        @(negedge clk);
        for (int c = 0; c < 3; c++) if (!led_n[c]) lc[c]++;
      end
      check_val(lc[0], w.e0, {w.tag, " red"});
      check_val(lc[1], w.e1, {w.tag, " green"});
      check_val(lc[2], w.e2, {w.tag, " blue"});
      void'(q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int f[3];
    logic [2:0] prev;
    int lows;
    repeat (4) @(negedge clk);
    check_val(int'(led_n), 7, "R1 led_n during reset");
    rst = 1'b0;
    @(negedge clk);
    check_val(int'(led_n), 7, "R1 led_n after reset");
    push_win(0, 0, 0, PER, "R1 zero brightness after reset");
    wait (q.size() == 0);

    brightness(15, 7, 1, "R2 levels 15/7/1");
    brightness(12, 13, 0, "R2 levels 12/13/0");
    // R5: new bus value without a load strobe
    @(negedge clk);
    setting = 24'h0F0F0F;
    repeat (PER + 80) @(negedge clk);
    push_win(ref_duty(12), ref_duty(13), 0, PER, "R5 no load no change");
    wait (q.size() == 0);
    brightness(10, 11, 14, "R2 levels 10/11/14");
    brightness(9, 9, 9, "R2 levels 9/9/9");

    // R7: period starts of green and blue relative to red
    f = '{-1, -1, -1};
    prev = led_n;
    for (int i = 0; i < 2 * PER + 50; i++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++)
        if (prev[c] && !led_n[c] && f[c] < 0 && (c == 0 || f[0] >= 0)) f[c] = i;
      prev = led_n;
    end
    check_val(f[1] - f[0], PER - PER/3, "R7 green lag");
    check_val(f[2] - f[0], PER - (2*PER)/3, "R7 blue lag");

    // R8: mid-period load must not cut the current period short
    prev = led_n;
    while (!(prev[0] && !led_n[0])) begin
      prev = led_n;
      @(negedge clk);
    end
    repeat (200) @(negedge clk);
    apply(24'h09090F);
    lows = 0;
    for (int i = 203; i < PER; i++) begin
      @(negedge clk);
      if (!led_n[0]) lows++;
    end
    check_val(lows, 0, "R8 old duty finishes period");
    @(negedge clk);
    check_val(int'(led_n[0]), 0, "R8 new duty at wrap");

    brightness(15, 15, 15, "R2 levels 15/15/15");
    mask_run(1, 2, 3);
    mask_run(4, 5, 6);
    mask_run(7, 8, 9);
    mask_run(10, 11, 12);
    mask_run(13, 14, 15);
    finish_run();
  end
endmodule